// File: doc/BRIEF.md
# Serial Command Decoder with Row and Column Parity

This block is a serial peripheral slave that takes 16-bit command words from a host controller and applies them to a small set of control flags and an internal register file. A word holds a 3-bit opcode, a 4-bit address, a data byte and an odd parity bit for that byte. Six of the opcodes are bare commands. They switch a modulation clamp flag, a gain-hold flag and a low-power sleep flag, or they clear the block. The other two opcodes read or write the register file. The file has six configuration bytes, a byte that holds the column parity of those six, and a status byte that can only be read.

The serial pins are sampled by the block's own clock through synchronizers, so all logic runs in one clock domain. The link has no handshake and the block cannot stall the host. The host's only obligation is timing: every SCLK high phase, SCLK low phase and CS level must last at least SYNC_STAGES+2 cycles of `clk`. A command takes effect when CS is released, and only if the window carried a whole number of words. The reply to a read leaves on SDO during the next CS window.

Top module: `spi_cmd_decoder`

## Requirements
- R1: A word is shifted in MSB first, with SDI sampled at SCLK rising edges (SCLK idles low). Bits 15:13 are the opcode, 12:9 the address, 8:1 the data and bit 0 the parity bit.
- R2: Commands execute only when CS is released, and only if the number of SCLK rising edges in the window is a nonzero multiple of 16. Any other window has no effect on flags, registers or the next reply.
- R3: When a window carries several whole words, only the last one is executed.
- R4: Opcode 000 sets `clamp_on` and opcode 001 clears it. Address and data bits are ignored.
- R5: Opcode 010 sets `sleep_mode`. Every other executed opcode clears it and also performs its own action.
- R6: Opcode 011 sets `agc_hold` and opcode 100 clears it.
- R7: Opcode 101 clears all seven data registers, the row-parity error flag, `clamp_on`, `agc_hold` and `sleep_mode`.
- R8: Opcode 111 stores the data byte at addresses 0–6. Writes to address 7 (status) and to addresses 8–15 change nothing.
- R9: On a write to addresses 0–6 where the data byte and the parity bit together hold an even number of ones, the byte is still stored and status bit 0 is set. That bit stays set until a soft reset.
- R10: Status bit 1 is 1 exactly when the XOR of registers 0–5 differs from register 6. Status bits 7:2 read as zero.
- R11: Opcode 110 queues a reply for the next window. SDO carries seven zeros, then the register value MSB first, then its odd parity bit. Addresses 8–15 read as zero. A window with no queued reply shifts out zeros.
- R12: SDO changes only after SCLK falling edges, and `sdo_oe` is low while CS is high.
- R13: After `rst_n` all registers and flags are zero and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | High while `sdo` should be driven onto the line |
| clamp_on | output | 1 | Modulation clamp flag |
| agc_hold | output | 1 | Gain-hold flag |
| sleep_mode | output | 1 | Low-power sleep flag |

## Verification
The hardest states to reach are windows whose clock count is not a whole number of words, and windows that carry two words. Both differ from a normal transfer only in how many SCLK edges come before CS rises. The bench's window task therefore takes an edge count as an argument and sweeps 0, 15, 16, 17, 31 and 32 edges. A sticky row-parity error only appears after a write that carries a deliberately wrong parity bit, so the register sweep writes every address twice, once with correct parity and once with inverted parity. It reads each address back, and the status byte, in the following windows.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int OP_W        = 3;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int FRAME_W     = OP_W + ADDR_W + DATA_W + 1;
  localparam int CNT_W       = $clog2(FRAME_W);
  localparam int N_CFG       = 6;
  localparam int COLPAR_ADDR = N_CFG;
  localparam int STATUS_ADDR = N_CFG + 1;

  typedef enum logic [OP_W-1:0] {
    OP_CLAMP_ON  = 3'd0,
    OP_CLAMP_OFF = 3'd1,
    OP_SLEEP     = 3'd2,
    OP_HOLD_ON   = 3'd3,
    OP_HOLD_OFF  = 3'd4,
    OP_SOFT_RST  = 3'd5,
    OP_READ      = 3'd6,
    OP_WRITE     = 3'd7
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              par;
  } frame_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int                 STAGES  = 2,
  parameter int                 WIDTH   = 3,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               sdi_s,
  input  logic               rsp_load_i,
  input  logic [FRAME_W-1:0] rsp_word_i,
  output frame_t             frame_o,
  output logic               exec_o,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  logic sclk_d, csn_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [FRAME_W-1:0] rx_q, tx_q, rsp_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               full_q, pend_q;
  frame_t             frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign cs_fall   = ~cs_n_s & csn_d;
  assign cs_rise   = cs_n_s & ~csn_d;

  // receive side: bit counter wraps per word, last whole word is latched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      frame_q <= '0;
    end else if (cs_fall) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (sclk_rise) begin
      rx_q <= {rx_q[FRAME_W-2:0], sdi_s};
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_q   <= '0;
        full_q  <= 1'b1;
        frame_q <= frame_t'({rx_q[FRAME_W-2:0], sdi_s});
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign exec_o  = cs_rise & full_q & (cnt_q == '0);
  assign frame_o = frame_q;

  // transmit side: reply queued at execution, loaded at next window start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= '0;
      pend_q <= 1'b0;
      tx_q   <= '0;
    end else begin
      if (rsp_load_i) begin
        rsp_q  <= rsp_word_i;
        pend_q <= 1'b1;
      end else if (cs_fall) begin
        pend_q <= 1'b0;
      end
      if (cs_fall)        tx_q <= pend_q ? rsp_q : '0;
      else if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo_o    = tx_q[FRAME_W-1];
  assign sdo_oe_o = ~cs_n_s;
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  frame_t             frame_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               wr_en_o,
  output logic               wr_par_ok_o,
  output logic               soft_clr_o,
  output logic               rsp_load_o,
  output logic [FRAME_W-1:0] rsp_word_o,
  output logic               clamp_o,
  output logic               hold_o,
  output logic               sleep_o
);
  logic clamp_q, hold_q, sleep_q;

  assign addr_o      = frame_i.addr;
  assign wr_data_o   = frame_i.data;
  assign wr_par_ok_o = ^{frame_i.data, frame_i.par};
  assign wr_en_o     = exec_i && (frame_i.op == OP_WRITE);
  assign soft_clr_o  = exec_i && (frame_i.op == OP_SOFT_RST);
  assign rsp_load_o  = exec_i && (frame_i.op == OP_READ);
  assign rsp_word_o  = {{(FRAME_W-DATA_W-1){1'b0}}, rd_data_i, ~^rd_data_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= 1'b0;
      hold_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (exec_i) begin
      sleep_q <= (frame_i.op == OP_SLEEP);
      case (frame_i.op)
        OP_CLAMP_ON:  clamp_q <= 1'b1;
        OP_CLAMP_OFF: clamp_q <= 1'b0;
        OP_HOLD_ON:   hold_q  <= 1'b1;
        OP_HOLD_OFF:  hold_q  <= 1'b0;
        OP_SOFT_RST: begin
          clamp_q <= 1'b0;
          hold_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign clamp_o = clamp_q;
  assign hold_o  = hold_q;
  assign sleep_o = sleep_q;
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr_i,
  input  logic              wr_en_i,
  input  logic              wr_par_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [N_CFG:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]          colx, status;
  logic                       row_err_q, col_mis;

  for (genvar i = 0; i <= N_CFG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= '0;
      else if (soft_clr_i)                            q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(i))       q <= wr_data_i;
    end
    assign regs[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          row_err_q <= 1'b0;
    else if (soft_clr_i) row_err_q <= 1'b0;
    else if (wr_en_i && addr_i <= ADDR_W'(COLPAR_ADDR) && !wr_par_ok_i)
      row_err_q <= 1'b1;
  end

  always_comb begin
    colx = '0;
    for (int i = 0; i < N_CFG; i++) colx = colx ^ regs[i];
  end

  assign col_mis = (colx != regs[COLPAR_ADDR]);
  assign status  = {{(DATA_W-2){1'b0}}, col_mis, row_err_q};

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i <= N_CFG; i++)
      if (addr_i == ADDR_W'(i)) rd_data_o = regs[i];
    if (addr_i == ADDR_W'(STATUS_ADDR)) rd_data_o = status;
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic clamp_on,
  output logic agc_hold,
  output logic sleep_mode
);
  logic [2:0]         pins_s;
  logic               exec;
  frame_t             frame;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wr_data, rd_data;
  logic               wr_en, wr_par_ok, soft_clr, rsp_load;
  logic [FRAME_W-1:0] rsp_word;
  logic               cs_n_s;

  spi_cmd_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({cs_n, sclk, sdi}),
    .sync_o (pins_s)
  );

  assign cs_n_s = pins_s[2];

  spi_cmd_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[1]),
    .cs_n_s    (cs_n_s),
    .sdi_s     (pins_s[0]),
    .rsp_load_i(rsp_load),
    .rsp_word_i(rsp_word),
    .frame_o   (frame),
    .exec_o    (exec),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe)
  );

  spi_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec),
    .frame_i    (frame),
    .rd_data_i  (rd_data),
    .addr_o     (addr),
    .wr_data_o  (wr_data),
    .wr_en_o    (wr_en),
    .wr_par_ok_o(wr_par_ok),
    .soft_clr_o (soft_clr),
    .rsp_load_o (rsp_load),
    .rsp_word_o (rsp_word),
    .clamp_o    (clamp_on),
    .hold_o     (agc_hold),
    .sleep_o    (sleep_mode)
  );

  spi_cmd_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr_i (soft_clr),
    .wr_en_i    (wr_en),
    .wr_par_ok_i(wr_par_ok),
    .addr_i     (addr),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data)
  );
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk
  import spi_cmd_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic exec,
  input op_e  op,
  input logic sdo_oe,
  input logic clamp_on,
  input logic agc_hold,
  input logic sleep_mode
);
  p_clamp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_CLAMP_ON |=> clamp_on);
  p_clamp_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_CLAMP_OFF |=> !clamp_on);
  p_sleep_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_SLEEP |=> sleep_mode);
  p_wake_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op != OP_SLEEP |=> !sleep_mode);
  p_hold_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_HOLD_ON |=> agc_hold);
  p_hold_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_HOLD_OFF |=> !agc_hold);
  p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_SOFT_RST |=> !clamp_on && !agc_hold && !sleep_mode);
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(clamp_on) && $stable(agc_hold) && $stable(sleep_mode));
  p_oe_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdo_oe);
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .exec      (exec),
  .op        (frame.op),
  .sdo_oe    (sdo_oe),
  .clamp_on  (clamp_on),
  .agc_hold  (agc_hold),
  .sleep_mode(sleep_mode)
);

// File: tb/test_spi_cmd_decoder.sv
module test_spi_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, clamp_on, agc_hold, sleep_mode;
  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_reg [7];
  logic        m_rowerr = 1'b0, m_clamp = 1'b0, m_hold = 1'b0, m_sleep = 1'b0;
  logic        m_pend = 1'b0;
  logic [15:0] m_rsp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_decoder i_spi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .clamp_on(clamp_on),
    .agc_hold(agc_hold), .sleep_mode(sleep_mode)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1: word layout {op[2:0], addr[3:0], data[7:0], parity}
  function automatic logic [15:0] mk(input int op, input int a, input int d, input bit bad_par);
    logic [7:0] dd = 8'(d);
    return {3'(op), 4'(a), dd, (~^dd) ^ bad_par};
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] x = '0;
    for (int i = 0; i < 6; i++) x ^= m_reg[i];
    if (a < 7)  return m_reg[a];
    if (a == 7) return {6'b0, x != m_reg[6], m_rowerr};
    return '0;
  endfunction

  task automatic m_apply(input logic [15:0] f);
    logic [2:0] op = f[15:13];
    logic [3:0] a  = f[12:9];
    logic [7:0] d  = f[8:1];
    logic [7:0] v;
    if (op != 3'd2) m_sleep = 1'b0;
    case (op)
      3'd0: m_clamp = 1'b1;
      3'd1: m_clamp = 1'b0;
      3'd2: m_sleep = 1'b1;
      3'd3: m_hold = 1'b1;
      3'd4: m_hold = 1'b0;
      3'd5: begin
        m_clamp = 1'b0; m_hold = 1'b0; m_rowerr = 1'b0;
        for (int i = 0; i < 7; i++) m_reg[i] = '0;
      end
      3'd6: begin
        v = m_read(a);
        m_pend = 1'b1;
        m_rsp = {7'b0, v, ~^v};
      end
      default: if (a < 7) begin
        m_reg[a] = d;
        if (^f[8:0] == 1'b0) m_rowerr = 1'b1;
      end
    endcase
  endtask

  // one CS window with nbits SCLK pulses taken MSB first from bits
  task automatic window(input logic [31:0] bits, input int nbits, input string tag);
    logic [15:0] exp_sdo = m_pend ? m_rsp : 16'h0;
    logic [15:0] got = '0;
    bit moved = 1'b0;
    logic s0, s1;
    m_pend = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[31-i];
      wait_clk(HALF);
      s0 = sdo;
      if (i == 0) chk({"R12 oe ", tag}, 32'(sdo_oe), 32'd1);
      if (i < 16) got[15-i] = s0;
      sclk = 1'b1;
      wait_clk(HALF);
      s1 = sdo;
      if (s1 !== s0) moved = 1'b1;
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3*HALF);
    if (nbits >= 16) chk({"R11 reply ", tag}, 32'(got), 32'(exp_sdo));
    if (nbits > 0)   chk({"R12 sdo held in high phase ", tag}, 32'(moved), 32'd0);
    chk({"R12 oe idle ", tag}, 32'(sdo_oe), 32'd0);
    if (nbits == 16) m_apply(bits[31:16]);
    if (nbits == 32) m_apply(bits[15:0]);
    chk({"R4 clamp ", tag}, 32'(clamp_on), 32'(m_clamp));
    chk({"R6 hold ", tag},  32'(agc_hold), 32'(m_hold));
    chk({"R5 sleep ", tag}, 32'(sleep_mode), 32'(m_sleep));
  endtask

  task automatic frame1(input logic [15:0] f, input string tag);
    window({f, 16'h0}, 16, tag);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) m_reg[i] = '0;
    wait_clk(5);
    chk("R13 oe in reset", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R13 clamp", 32'(clamp_on), 32'd0);
    chk("R13 hold", 32'(agc_hold), 32'd0);
    chk("R13 sleep", 32'(sleep_mode), 32'd0);
    chk("R13 oe", 32'(sdo_oe), 32'd0);
    // R13: every register reads zero after reset
    for (int a = 0; a < 8; a++) frame1(mk(6, a, 8'h5a, 0), "R13 read");

    // R4 R5 R6 R7: command-only sweep with junk address and data
    for (int k = 0; k < 30; k++)
      frame1(mk((k*5+3) % 6, k, k*29+11, k[0]), "R5 command sweep");

    // R8 R9: write every address with good then bad parity, read back
    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 2; p++) begin
        frame1(mk(7, a, a*53 + p*17 + 7, p[0]), "R9 write");
        frame1(mk(6, a, 0, 0), "R8 read");
        frame1(mk(6, 7, 0, 0), "R9 status");
      end
    frame1(mk(6, 0, 0, 0), "R9 flush");

    // R10: column parity matched, then broken
    frame1(mk(5, 0, 0, 0), "R7 soft reset");
    for (int a = 0; a < 6; a++) frame1(mk(7, a, 8'h11 << (a % 4) ^ a, 0), "R10 cfg");
    frame1(mk(7, 6, (8'h11 ^ 8'h23 ^ 8'h46 ^ 8'h8b ^ 8'h15 ^ 8'h27), 0), "R10 colpar");
    frame1(mk(6, 7, 0, 0), "R10 status match");
    frame1(mk(7, 3, 8'hff, 0), "R10 break");
    frame1(mk(6, 7, 0, 0), "R10 status mismatch");
    frame1(mk(6, 6, 0, 0), "R10 flush");

    // R7: soft reset from a busy state, then read everything back
    frame1(mk(0, 0, 0, 0), "R7 setup clamp");
    frame1(mk(3, 0, 0, 0), "R7 setup hold");
    frame1(mk(7, 2, 8'h3c, 1), "R7 setup parity error");
    frame1(mk(2, 0, 0, 0), "R7 setup sleep");
    frame1(mk(5, 9, 8'hff, 1), "R7 soft reset");
    for (int a = 0; a < 8; a++) frame1(mk(6, a, 0, 0), "R7 read after clear");
    frame1(mk(4, 0, 0, 0), "R7 flush");

    // R2 R3: windows with odd edge counts, empty windows and two words
    window({mk(0, 0, 0, 0), 16'h0}, 15, "R2 15 edges");
    window({mk(0, 0, 0, 0), 16'hffff}, 17, "R2 17 edges");
    window({mk(3, 0, 0, 0), mk(0, 0, 0, 0)}, 31, "R2 31 edges");
    window(32'h0, 0, "R2 no edges");
    window({mk(6, 0, 0, 0), 16'h0}, 15, "R2 aborted read");
    window({mk(0, 0, 0, 0), 16'h0}, 16, "R2 no reply after abort");
    window({mk(1, 0, 0, 0), mk(3, 0, 0, 0)}, 32, "R3 two words");
    window({mk(6, 7, 0, 0), mk(2, 0, 0, 0)}, 32, "R3 read then sleep");
    window({mk(0, 0, 0, 0), 16'h0}, 16, "R3 no reply from first word");
    frame1(mk(2, 0, 0, 0), "R5 sleep");
    frame1(mk(7, 1, 8'h42, 0), "R5 wake by write");
    frame1(mk(2, 0, 0, 0), "R5 sleep again");
    frame1(mk(6, 1, 0, 0), "R5 wake by read");
    frame1(mk(4, 0, 0, 0), "R5 final");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule